// File: doc/BRIEF.md
# 2421-Coded Decimal Adder

This block adds two unsigned four-digit decimal numbers whose digits are held in the self-complementing 2421 code. It also takes a one-bit carry-in. A 16-bit binary carry look-ahead core first adds the raw operand bits. The core is built from 4-bit look-ahead groups. A parameter chooses how the group carries are formed: each group can pass its carry straight to the next group, or the group generate and propagate terms can feed a second look-ahead level.

A correction stage follows the core. It works on one digit at a time. From the binary digit sum and the binary carries at the digit edges, it recovers the decimal value of each digit pair. It then forms a decimal generate and propagate pair for each digit. These pairs drive a look-ahead unit of the same kind, so the decimal carries are not rippled digit by digit. Each digit is written back as a valid 2421 code. The block is purely combinational and can sit inside any pipeline stage.

Top module: `dec2421_adder`

## Requirements
- R1: Digit k of each operand and of the sum occupies bits [4k+3:4k], with digit 0 the least significant. Values 0..4 are coded 0000..0100 and values 5..9 are coded 1011..1111 (value + 6).
- R2: For valid inputs, sum_out encodes (X + Y + cin) mod 10000 in 2421 code, where X and Y are the decimal values of the operands.
- R3: carry_out is 1 exactly when X + Y + cin is 10000 or more.
- R4: cin adds one unit to the least significant digit. For example, 0004 + 0000 + 1 gives a low digit of 1011.
- R5: A decimal carry reaches every digit. For example, 9999 + 0000 + 1 gives 0000 with carry_out 1.
- R6: Every digit of sum_out is a valid 2421 code (0000..0100 or 1011..1111).
- R7: The chained-group core (TWO_LEVEL=0) and the two-level core (TWO_LEVEL=1) produce identical sum_out and carry_out for every input.
- R8: The largest case, 9999 + 9999 + 1, gives 9999 with carry_out 1.
- R9: The block has no latency. Outputs follow the inputs within the same clock period, with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_in | input | 16 | First operand, four 2421 digits |
| y_in | input | 16 | Second operand, four 2421 digits |
| cin | input | 1 | Carry into the least significant digit |
| sum_out | output | 16 | Sum, four 2421 digits |
| carry_out | output | 1 | Decimal carry out of the most significant digit |

## Verification
The bench builds the adder twice with DIGITS=4: once with TWO_LEVEL=1 and once with TWO_LEVEL=0. Driving both copies with the same operands exercises the second-level look-ahead path and the chained group path together, which lets the bench compare them on every vector. Directed operands push decimal carries through all four digits and across the 4/5 code gap. Random valid operand pairs cover the remaining combinations of group carries.

// File: rtl/dec2421_pkg.sv
package dec2421_pkg;
  localparam int DIG_W = 4;
  typedef logic [DIG_W-1:0] code_t;
endpackage

// File: rtl/cla_carry_gen.sv
module cla_carry_gen #(
  parameter int W = 4
) (
  input  logic [W-1:0] g,
  input  logic [W-1:0] p,
  input  logic         cin,
  output logic [W:0]   c
);
  always_comb begin
    logic acc;
    logic prod;
    c[0] = cin;
    for (int k = 1; k <= W; k++) begin
      acc = 1'b0;
      for (int j = -1; j < k; j++) begin
        prod = (j < 0) ? cin : g[j];
        for (int m = j + 1; m < k; m++) prod = prod & p[m];
        acc = acc | prod;
      end
      c[k] = acc;
    end
  end

  // R2
  always_comb begin
    all_prop_chk: assert (!(&p) || (c[W] == cin));
  end
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         gg,
  output logic         gp
);
  logic [W-1:0] g, p;
  logic [W:0]   c;

  assign g = a & b;
  assign p = a ^ b;

  cla_carry_gen #(.W(W)) u_gen (.g(g), .p(p), .cin(cin), .c(c));

  assign sum  = p ^ c[W-1:0];
  assign cout = c[W];
  assign gp   = &p;

  always_comb begin
    logic prod;
    gg = 1'b0;
    for (int j = 0; j < W; j++) begin
      prod = g[j];
      for (int m = j + 1; m < W; m++) prod = prod & p[m];
      gg = gg | prod;
    end
  end
endmodule

// File: rtl/bin_cla_core.sv
module bin_cla_core #(
  parameter int NG        = 4,
  parameter int GW        = 4,
  parameter bit TWO_LEVEL = 1'b1,
  localparam int W        = NG * GW
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic [NG:0]  bcar
);
  assign bcar[0] = cin;

  genvar gi;
  for (gi = 0; gi < NG; gi++) begin : g_grp
    logic          cin_l, cout_l, gg_l, gp_l;
    logic [GW-1:0] s_l;

    if (TWO_LEVEL) begin : g_fed
      assign cin_l = g_lvl2.c2[gi];
      // R7
      always_comb begin
        lvl2_carry_chk: assert (cout_l == g_lvl2.c2[gi+1]);
      end
    end else begin : g_chain
      if (gi == 0) begin : g_first
        assign cin_l = cin;
      end else begin : g_next
        assign cin_l = g_grp[gi-1].cout_l;
      end
      // R7
      always_comb begin
        chain_carry_chk: assert (cout_l == (gg_l | (gp_l & cin_l)));
      end
    end

    cla_group #(.W(GW)) u_grp (
      .a(a[gi*GW +: GW]), .b(b[gi*GW +: GW]), .cin(cin_l),
      .sum(s_l), .cout(cout_l), .gg(gg_l), .gp(gp_l)
    );

    assign sum[gi*GW +: GW] = s_l;
    assign bcar[gi+1]       = cout_l;
  end

  if (TWO_LEVEL) begin : g_lvl2
    logic [NG-1:0] gv, pv;
    logic [NG:0]   c2;
    for (genvar k = 0; k < NG; k++) begin : g_col
      assign gv[k] = g_grp[k].gg_l;
      assign pv[k] = g_grp[k].gp_l;
    end
    cla_carry_gen #(.W(NG)) u_lvl2 (.g(gv), .p(pv), .cin(cin), .c(c2));
  end
endmodule

// File: rtl/digit_fix.sv
module digit_fix
  import dec2421_pkg::*;
(
  input  code_t a_d,
  input  code_t b_d,
  input  code_t s_d,
  input  logic  ci_b,
  input  logic  co_b,
  input  logic  cd_in,
  output logic  dg,
  output logic  dp,
  output code_t q
);
  logic [5:0] v, t, r;

  always_comb begin
    v  = {1'b0, co_b, s_d} - {5'b0, ci_b}
         - (a_d[3] ? 6'd6 : 6'd0) - (b_d[3] ? 6'd6 : 6'd0);
    dg = (v >= 6'd10);
    dp = (v == 6'd9);
    t  = v + {5'b0, cd_in};
    r  = (t >= 6'd10) ? t - 6'd10 : t;
    q  = (r >= 6'd5) ? r[3:0] + 4'd6 : r[3:0];
  end

  // R2
  always_comb begin
    core_sum_chk: assert ({co_b, s_d} == {1'b0, a_d} + {1'b0, b_d} + {4'b0, ci_b});
  end

  // R6
  always_comb begin
    valid_code_chk: assert (q <= 4'd4 || q >= 4'd11);
  end
endmodule

// File: rtl/dec2421_adder.sv
module dec2421_adder
  import dec2421_pkg::*;
#(
  parameter int DIGITS    = 4,
  parameter bit TWO_LEVEL = 1'b1,
  localparam int W        = DIGITS * DIG_W
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic         cin,
  output logic [W-1:0] sum_out,
  output logic         carry_out
);
  logic [W-1:0]      bsum;
  logic [DIGITS:0]   bcar;
  logic [DIGITS-1:0] dgv, dpv;
  logic [DIGITS:0]   dc;

  bin_cla_core #(.NG(DIGITS), .GW(DIG_W), .TWO_LEVEL(TWO_LEVEL)) u_core (
    .a(x_in), .b(y_in), .cin(cin), .sum(bsum), .bcar(bcar)
  );

  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    code_t q_l;
    logic  dg_l, dp_l;
    digit_fix u_fix (
      .a_d(x_in[d*DIG_W +: DIG_W]), .b_d(y_in[d*DIG_W +: DIG_W]),
      .s_d(bsum[d*DIG_W +: DIG_W]), .ci_b(bcar[d]), .co_b(bcar[d+1]),
      .cd_in(dc[d]), .dg(dg_l), .dp(dp_l), .q(q_l)
    );
    assign dgv[d] = dg_l;
    assign dpv[d] = dp_l;
    assign sum_out[d*DIG_W +: DIG_W] = q_l;
  end

  cla_carry_gen #(.W(DIGITS)) u_dec_gen (.g(dgv), .p(dpv), .cin(cin), .c(dc));

  assign carry_out = dc[DIGITS];

  // R3
  always_comb begin
    zero_sum_chk: assert (!(x_in == '0 && y_in == '0) ||
                          (carry_out == 1'b0 && sum_out == {{(W-1){1'b0}}, cin}));
  end
endmodule

// File: tb/dec2421_adder_tb.sv
module dec2421_adder_tb;
  logic        clk = 1'b0;
  logic [15:0] x_in = '0, y_in = '0;
  logic        cin = 1'b0;
  logic [15:0] sum_a, sum_b;
  logic        co_a, co_b;
  int          n_chk = 0, n_fail = 0, cycles = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dec2421_adder #(.DIGITS(4), .TWO_LEVEL(1'b1)) u_dut (
    .x_in(x_in), .y_in(y_in), .cin(cin), .sum_out(sum_a), .carry_out(co_a));
  dec2421_adder #(.DIGITS(4), .TWO_LEVEL(1'b0)) u_chain (
    .x_in(x_in), .y_in(y_in), .cin(cin), .sum_out(sum_b), .carry_out(co_b));

  // R1 encoding
  function automatic logic [15:0] enc(input int v);
    logic [15:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      int d = (v / (10 ** k)) % 10;
      r[k*4 +: 4] = (d < 5) ? 4'(d) : 4'(d + 6);
    end
    return r;
  endfunction

  function automatic int dec(input logic [15:0] c);
    int v = 0;
    for (int k = 3; k >= 0; k--) begin
      int d = int'(c[k*4 +: 4]);
      v = v * 10 + ((d >= 11) ? d - 6 : d);
    end
    return v;
  endfunction

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input int xv, input int yv, input bit c, input string tag);
    int tot;
    logic [15:0] es;
    logic        ec;
    bit          valid;
    @(posedge clk);
    x_in = enc(xv); y_in = enc(yv); cin = c;
    tot = xv + yv + int'(c);
    es = enc(tot % 10000);
    ec = (tot >= 10000);
    @(negedge clk);
    chk({co_a, sum_a} == {ec, es}, tag, {co_a, sum_a}, {ec, es});
    // R7 both core variants agree
    chk({co_b, sum_b} == {co_a, sum_a}, "R7", {co_b, sum_b}, {co_a, sum_a});
    // R6 every digit is a legal code
    valid = 1'b1;
    for (int k = 0; k < 4; k++)
      if (sum_a[k*4 +: 4] > 4'd4 && sum_a[k*4 +: 4] < 4'd11) valid = 1'b0;
    chk(valid, "R6", {1'b0, sum_a}, {1'b0, es});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!done && cycles > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      report();
    end
  end

  initial begin
    @(negedge clk);
    // R9 quiescent zero inputs give zero outputs with no clock
    chk({co_a, sum_a} == 17'h0, "R9", {co_a, sum_a}, 17'h0);
    run(0, 0, 1'b0, "R2 zero");
    run(1234, 4321, 1'b0, "R2 mixed");
    run(0, 0, 1'b1, "R4 cin");
    run(4, 0, 1'b1, "R4 code gap R1");
    run(5, 5, 1'b0, "R1 digit carry");
    run(9999, 0, 1'b1, "R5 full ripple");
    run(9999, 9999, 1'b1, "R8 max");
    run(9999, 9999, 1'b0, "R3 near max");
    run(5000, 5000, 1'b0, "R3 top carry");
    run(4999, 5000, 1'b0, "R3 no carry");
    run(4999, 5000, 1'b1, "R3 edge carry");
    run(3456, 6543, 1'b1, "R5 all nines plus one");
    for (int i = 0; i < 400; i++)
      run(int'($urandom_range(0, 9999)), int'($urandom_range(0, 9999)),
          1'($urandom_range(0, 1)), "R2 random");
    // R9 change inputs mid-period and observe within the same period
    x_in = enc(17); y_in = enc(25); cin = 1'b0;
    #2;
    chk(sum_a == enc(42), "R9", {co_a, sum_a}, {1'b0, enc(42)});
    done = 1'b1;
    report();
  end
endmodule